// File: doc/BRIEF.md
# Byte DMA Engine with Burst-Boundary Stop

This block moves bytes between a USB endpoint buffer and an external data bus. An eight-entry staging FIFO sits between the two sides. Software loads a 32-bit transfer counter with a byte total, then writes a one-byte command that picks the direction and the mode. IN moves bytes from the bus to the endpoint. OUT moves bytes from the endpoint to the bus. In burst mode, intake is grouped into bursts of `burst_len` bytes. The counter then counts down one for each byte handled on the endpoint side, and reading it back gives the number of bytes still outstanding.

There are three ways to end a transfer early. A soft reset command returns the whole engine to its power-up state. An abort command cuts an immediate-mode transfer short on the spot. A graceful stop command lets the current burst finish, then halts intake and drains whatever the FIFO still holds. Two sticky interrupt flags report a natural finish and a completed graceful stop. Software clears each flag by writing a one to it.

Top module: `dma_burst_engine`

## Requirements
- R1: After `rst_n` is released, `cnt_rdata` is 0, `irq_stat` is 00 and `busy` is 0. Command 11h puts the engine back in that same state from any state, and the FIFO contents are thrown away.
- R2: While the engine is idle, `cnt_wr` loads `cnt_wdata` into the counter. A write made while `busy` is 1 is ignored.
- R3: The start commands are 04h (burst IN, bus to endpoint), 05h (burst OUT, endpoint to bus), 06h (immediate IN) and 07h (immediate OUT). Each byte reaches the far side unchanged and in order.
- R4: The counter drops by one for each byte handed over on the endpoint side. When all bytes are taken in and the FIFO is empty, `busy` falls and the done flag `irq_stat[0]` is set. A start with a count of 0 completes at once and sets the done flag.
- R5: The FIFO never holds more than 8 bytes. Intake stalls while the FIFO is full.
- R6: An OUT transfer does not report done while bytes are still waiting in the FIFO for the bus.
- R7: Command 13h during a transfer stops intake only once the number of bytes taken in is a whole multiple of the burst length. Bytes already in the FIFO are then delivered: IN bytes go to the endpoint. For OUT, bytes not yet taken stay in the endpoint buffer, and the counter shows how many remain. The stop flag `irq_stat[1]` is then set.
- R8: Command 13h while idle sets `irq_stat[1]` on the next cycle.
- R9: Command 12h during an immediate-mode transfer (06h/07h) ends it on the next cycle. It discards the FIFO, keeps the counter value and sets no flag. Command 12h has no effect on a burst-mode transfer.
- R10: Codes 14h to 20h and 29h to FFh change nothing: neither `busy`, nor the counter, nor the flags.
- R11: Writing 1 to a bit of `irq_clr` clears that flag. Writing 0 leaves it as it is. A flag that is set in the same cycle as it is cleared stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 32 | Byte total to load |
| cnt_rdata | output | 32 | Bytes still to transfer |
| burst_len | input | 16 | Burst length in bytes, sampled at start |
| irq_clr | input | 2 | Write-1-to-clear for the flags |
| irq_stat | output | 2 | Bit 0: done; bit 1: graceful stop complete |
| busy | output | 1 | Transfer in progress |
| bus_rx_valid | input | 1 | Bus byte offered (IN) |
| bus_rx_data | input | 8 | Bus byte |
| bus_rx_ready | output | 1 | Engine takes bus byte |
| bus_tx_valid | output | 1 | Byte offered to bus (OUT) |
| bus_tx_data | output | 8 | Byte to bus |
| bus_tx_ready | input | 1 | Bus takes byte |
| ep_rd_valid | input | 1 | Endpoint byte offered (OUT) |
| ep_rd_data | input | 8 | Endpoint byte |
| ep_rd_ready | output | 1 | Engine takes endpoint byte |
| ep_wr_valid | output | 1 | Byte offered to endpoint (IN) |
| ep_wr_data | output | 8 | Byte to endpoint |
| ep_wr_ready | input | 1 | Endpoint takes byte |

## Verification
The assertions assume that at most one command arrives per cycle. They also assume that `cnt_wr` never coincides with a command, and that `burst_len` is nonzero whenever a start command is issued. The stimulus keeps to all of this: one task drives each command, register writes and command strobes go in separate cycles, and every start uses a burst length of at least 2. The valid and ready inputs are driven half a cycle before each clock edge and held stable through it. The bench can therefore count a byte as transferred exactly when both signals are high before that edge.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

   localparam logic [7:0] CMD_RUN_BURST_IN  = 8'h04;
   localparam logic [7:0] CMD_RUN_BURST_OUT = 8'h05;
   localparam logic [7:0] CMD_RUN_IMM_IN    = 8'h06;
   localparam logic [7:0] CMD_RUN_IMM_OUT   = 8'h07;
   localparam logic [7:0] CMD_SOFT_RESET    = 8'h11;
   localparam logic [7:0] CMD_ABORT_IMM     = 8'h12;
   localparam logic [7:0] CMD_SOFT_STOP     = 8'h13;

   typedef struct packed {
      logic start;
      logic start_in;
      logic start_imm;
      logic rst_all;
      logic stop_now;
      logic stop_soft;
      logic reserved;
   } dma_cmd_t;

   localparam int unsigned IRQ_DONE = 0;
   localparam int unsigned IRQ_STOP = 1;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
   import dma_eng_pkg::*;
(
   input  logic       valid,
   input  logic [7:0] code,
   output dma_cmd_t   dec
);

   always_comb begin
      dec = '0;
      if (valid) begin
         if (code == CMD_RUN_BURST_IN || code == CMD_RUN_BURST_OUT ||
             code == CMD_RUN_IMM_IN   || code == CMD_RUN_IMM_OUT) begin
            dec.start     = 1'b1;
            dec.start_in  = ~code[0];
            dec.start_imm = code[1];
         end
         dec.rst_all   = (code == CMD_SOFT_RESET);
         dec.stop_now  = (code == CMD_ABORT_IMM);
         dec.stop_soft = (code == CMD_SOFT_STOP);
         dec.reserved  = ((code >= 8'h14) && (code <= 8'h20)) || (code >= 8'h29);
      end
   end

endmodule

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = AW + 1;

   initial begin
      if (DEPTH < 2) $fatal(1, "dma_stage_fifo: DEPTH must be at least 2");
      if (WIDTH < 1) $fatal(1, "dma_stage_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp, wp_nx, rp_nx;
   logic [CW-1:0]    fill;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign full  = (fill == CW'(DEPTH));
   assign empty = (fill == '0);
   assign dout  = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else if (clr) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         if (push && !pop)      fill <= fill + 1'b1;
         else if (pop && !push) fill <= fill - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wp] <= din;
   end

   // R5
   fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R5
   fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R5
   fifo_fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
   import dma_eng_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned BURST_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dma_cmd_t         cmd,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [BURST_W-1:0] burst_len,
   input  logic [1:0]       irq_clr,
   input  logic             push,
   input  logic             ep_fire,
   input  logic             fifo_empty,
   output logic             running,
   output logic             in_dir,
   output logic             intake_ok,
   output logic             halt_intake,
   output logic             fifo_clr,
   output logic [CNT_W-1:0] rem,
   output logic [1:0]       irq
);

   logic               imm, stop_pend, finish, abort;
   logic [CNT_W-1:0]   adm_left;
   logic [BURST_W-1:0] burst_q, pos, pos_nx;
   logic [BURST_W:0]   pos_inc;
   logic [1:0]         irq_set;

   always_comb begin
      halt_intake = stop_pend && (pos == '0);
      intake_ok   = running && !halt_intake && (adm_left != '0);
      abort       = running && imm && cmd.stop_now;
      finish      = running && !abort && fifo_empty && ((adm_left == '0) || halt_intake);
      fifo_clr    = cmd.rst_all || abort;
      pos_inc     = {1'b0, pos} + 1'b1;
      pos_nx      = (pos_inc >= {1'b0, burst_q}) ? '0 : pos_inc[BURST_W-1:0];
      irq_set              = '0;
      irq_set[IRQ_DONE]    = finish && (adm_left == '0);
      irq_set[IRQ_STOP]    = (finish && stop_pend) || (cmd.stop_soft && !running);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running   <= 1'b0;
         imm       <= 1'b0;
         in_dir    <= 1'b0;
         stop_pend <= 1'b0;
         adm_left  <= '0;
         burst_q   <= '0;
         pos       <= '0;
         rem       <= '0;
         irq       <= '0;
      end else if (cmd.rst_all) begin
         running   <= 1'b0;
         imm       <= 1'b0;
         in_dir    <= 1'b0;
         stop_pend <= 1'b0;
         adm_left  <= '0;
         burst_q   <= '0;
         pos       <= '0;
         rem       <= '0;
         irq       <= '0;
      end else begin
         irq <= (irq & ~irq_clr) | irq_set;
         if (!running && cnt_wr)  rem <= cnt_wdata;
         else if (ep_fire)        rem <= rem - 1'b1;
         if (!running) begin
            if (cmd.start) begin
               running   <= 1'b1;
               imm       <= cmd.start_imm;
               in_dir    <= cmd.start_in;
               adm_left  <= rem;
               burst_q   <= burst_len;
               pos       <= '0;
               stop_pend <= 1'b0;
            end
         end else if (abort || finish) begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
         end else begin
            if (push) begin
               adm_left <= adm_left - 1'b1;
               pos      <= pos_nx;
            end
            if (cmd.stop_soft) stop_pend <= 1'b1;
         end
      end
   end

   // R1
   soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.rst_all |=> (rem == '0) && (irq == '0) && !running);
   // R2
   counter_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running && !cmd.rst_all |=> rem <= $past(rem));
   // R7
   burst_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_intake |-> !push);
   // R9
   abort_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !running && (irq == ($past(irq) & ~$past(irq_clr))));
   // R10
   reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.reserved && !running && !cnt_wr |=> !running && $stable(rem));

endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
   import dma_eng_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned BURST_W    = 16,
   parameter int unsigned FIFO_DEPTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [7:0]         cmd_code,
   input  logic               cnt_wr,
   input  logic [CNT_W-1:0]   cnt_wdata,
   output logic [CNT_W-1:0]   cnt_rdata,
   input  logic [BURST_W-1:0] burst_len,
   input  logic [1:0]         irq_clr,
   output logic [1:0]         irq_stat,
   output logic               busy,
   input  logic               bus_rx_valid,
   input  logic [DATA_W-1:0]  bus_rx_data,
   output logic               bus_rx_ready,
   output logic               bus_tx_valid,
   output logic [DATA_W-1:0]  bus_tx_data,
   input  logic               bus_tx_ready,
   input  logic               ep_rd_valid,
   input  logic [DATA_W-1:0]  ep_rd_data,
   output logic               ep_rd_ready,
   output logic               ep_wr_valid,
   output logic [DATA_W-1:0]  ep_wr_data,
   input  logic               ep_wr_ready
);

   initial begin
      if (CNT_W < 2 || CNT_W > 32) $fatal(1, "dma_burst_engine: CNT_W out of range");
      if (BURST_W < 1)             $fatal(1, "dma_burst_engine: BURST_W must be positive");
   end

   dma_cmd_t          cmd;
   logic              running, in_dir, intake_ok, halt_intake, fifo_clr;
   logic              fifo_full, fifo_empty, push, pop, ep_fire, src_valid;
   logic [DATA_W-1:0] src_data, fifo_dout;

   dma_cmd_decode u_dec (
      .valid (cmd_valid),
      .code  (cmd_code),
      .dec   (cmd)
   );

   dma_xfer_ctrl #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd         (cmd),
      .cnt_wr      (cnt_wr),
      .cnt_wdata   (cnt_wdata),
      .burst_len   (burst_len),
      .irq_clr     (irq_clr),
      .push        (push),
      .ep_fire     (ep_fire),
      .fifo_empty  (fifo_empty),
      .running     (running),
      .in_dir      (in_dir),
      .intake_ok   (intake_ok),
      .halt_intake (halt_intake),
      .fifo_clr    (fifo_clr),
      .rem         (cnt_rdata),
      .irq         (irq_stat)
   );

   always_comb begin
      src_valid    = in_dir ? bus_rx_valid : ep_rd_valid;
      src_data     = in_dir ? bus_rx_data  : ep_rd_data;
      bus_rx_ready = in_dir  && intake_ok && !fifo_full;
      ep_rd_ready  = !in_dir && intake_ok && !fifo_full;
      push         = intake_ok && !fifo_full && src_valid && !fifo_clr;
      ep_wr_valid  = running && in_dir  && !fifo_empty;
      bus_tx_valid = running && !in_dir && !fifo_empty;
      ep_wr_data   = fifo_dout;
      bus_tx_data  = fifo_dout;
      pop          = ((ep_wr_valid && ep_wr_ready) || (bus_tx_valid && bus_tx_ready)) && !fifo_clr;
      ep_fire      = in_dir ? (ep_wr_valid && ep_wr_ready) : push;
      busy         = running;
   end

   dma_stage_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fifo_clr),
      .push  (push),
      .din   (src_data),
      .pop   (pop),
      .dout  (fifo_dout),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   // R6
   done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_stat[IRQ_DONE]) |-> $past(fifo_empty));
   // R7
   halt_blocks_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_intake |-> !bus_rx_ready && !ep_rd_ready);
   // R3
   one_side_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rx_ready && ep_rd_ready) && !(bus_tx_valid && ep_wr_valid));

endmodule

// File: tb/dma_burst_engine_tb.sv
module dma_burst_engine_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic        cnt_wr = 1'b0;
   logic [31:0] cnt_wdata = '0;
   logic [31:0] cnt_rdata;
   logic [15:0] burst_len = 16'd4;
   logic [1:0]  irq_clr = '0;
   logic [1:0]  irq_stat;
   logic        busy;
   logic        bus_rx_valid = 1'b0, bus_rx_ready;
   logic [7:0]  bus_rx_data = '0;
   logic        bus_tx_valid, bus_tx_ready = 1'b0;
   logic [7:0]  bus_tx_data;
   logic        ep_rd_valid = 1'b0, ep_rd_ready;
   logic [7:0]  ep_rd_data = '0;
   logic        ep_wr_valid, ep_wr_ready = 1'b0;
   logic [7:0]  ep_wr_data;

   int   checks = 0;
   int   errors = 0;
   bit   done_flag = 0;
   int   src_lim = 0;
   int   src_sent = 0;
   int   snk_mode = 0;   // 0 ready, 1 held low, 2 toggling
   int   cyc = 0;
   logic [7:0] nxt = 8'h30;
   logic [7:0] exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   dma_burst_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
      .burst_len(burst_len), .irq_clr(irq_clr), .irq_stat(irq_stat), .busy(busy),
      .bus_rx_valid(bus_rx_valid), .bus_rx_data(bus_rx_data), .bus_rx_ready(bus_rx_ready),
      .bus_tx_valid(bus_tx_valid), .bus_tx_data(bus_tx_data), .bus_tx_ready(bus_tx_ready),
      .ep_rd_valid(ep_rd_valid), .ep_rd_data(ep_rd_data), .ep_rd_ready(ep_rd_ready),
      .ep_wr_valid(ep_wr_valid), .ep_wr_data(ep_wr_data), .ep_wr_ready(ep_wr_ready)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pop_cmp(input logic [7:0] got);
      if (exp_q.size() == 0) check(1'b0, "R3 byte with nothing pending", got, -1);
      else begin
         logic [7:0] e;
         e = exp_q.pop_front();
         check(got == e, "R3 byte order", got, e);
      end
   endtask

   // driver and monitor: inputs change at negedge, handshakes sampled just before posedge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         bus_rx_valid = (src_sent < src_lim);
         ep_rd_valid  = (src_sent < src_lim);
         bus_rx_data  = nxt;
         ep_rd_data   = nxt;
         bus_tx_ready = (snk_mode == 0) || (snk_mode == 2 && cyc[0]);
         ep_wr_ready  = bus_tx_ready;
         #(CLK_P/2 - 1);
         if (rst_n) begin
            if ((bus_rx_valid && bus_rx_ready) || (ep_rd_valid && ep_rd_ready)) begin
               exp_q.push_back(nxt);
               nxt = nxt + 8'd7;
               src_sent++;
            end
            if (ep_wr_valid && ep_wr_ready)   pop_cmp(ep_wr_data);
            if (bus_tx_valid && bus_tx_ready) pop_cmp(bus_tx_data);
         end
      end
   end

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL R4 watchdog: actual running expected finished");
      finish_run();
   end

   task automatic do_cmd(input logic [7:0] c);
      cmd_valid = 1'b1; cmd_code = c;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic load(input logic [31:0] n);
      cnt_wr = 1'b1; cnt_wdata = n;
      @(negedge clk);
      cnt_wr = 1'b0;
   endtask

   task automatic clr_irq(input logic [1:0] v);
      irq_clr = v;
      @(negedge clk);
      irq_clr = '0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
   endtask

   task automatic wait_sent(input int n);
      for (int i = 0; i < 3000 && src_sent < n; i++) @(negedge clk);
   endtask

   task automatic new_test(input int lim, input int mode, input logic [15:0] bl);
      src_sent = 0; src_lim = lim; snk_mode = mode; burst_len = bl;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cnt_rdata == 0, "R1 counter after reset", cnt_rdata, 0);
      check(irq_stat == 0, "R1 flags after reset", irq_stat, 0);
      check(busy == 0, "R1 busy after reset", busy, 0);

      // R3 R4 burst IN, 20 bytes, burst 4
      new_test(100, 0, 16'd4);
      load(32'd20);
      check(cnt_rdata == 20, "R2 counter load", cnt_rdata, 20);
      do_cmd(8'h04);
      wait_idle();
      check(src_sent == 20, "R3 bytes taken IN", src_sent, 20);
      check(exp_q.size() == 0, "R3 all bytes delivered IN", exp_q.size(), 0);
      check(cnt_rdata == 0, "R4 counter at zero", cnt_rdata, 0);
      check(irq_stat == 2'b01, "R4 done flag", irq_stat, 1);
      // R11 clear done
      clr_irq(2'b01);
      check(irq_stat == 2'b00, "R11 W1C clears done", irq_stat, 0);

      // R3 immediate OUT with toggling bus ready
      new_test(100, 2, 16'd3);
      load(32'd11);
      do_cmd(8'h07);
      wait_idle();
      check(src_sent == 11, "R3 bytes taken OUT", src_sent, 11);
      check(exp_q.size() == 0, "R3 all bytes delivered OUT", exp_q.size(), 0);
      check(irq_stat == 2'b01, "R4 done OUT", irq_stat, 1);
      clr_irq(2'b11);

      // R6 OUT waits for FIFO drain
      new_test(100, 1, 16'd16);
      load(32'd4);
      do_cmd(8'h05);
      wait_sent(4);
      repeat (3) @(negedge clk);
      check(cnt_rdata == 0, "R4 OUT counts endpoint reads", cnt_rdata, 0);
      check(busy == 1, "R6 busy while FIFO holds bytes", busy, 1);
      check(irq_stat[0] == 0, "R6 no done before drain", irq_stat[0], 0);
      snk_mode = 0;
      wait_idle();
      check(irq_stat[0] == 1, "R6 done after drain", irq_stat[0], 1);
      check(exp_q.size() == 0, "R6 drained bytes", exp_q.size(), 0);
      clr_irq(2'b11);

      // R7 graceful stop OUT mid burst: 3 of 8 taken, expect 8
      new_test(3, 0, 16'd8);
      load(32'd100);
      do_cmd(8'h05);
      wait_sent(3);
      do_cmd(8'h13);
      src_lim = 200;
      wait_idle();
      check(src_sent == 8, "R7 OUT stops at burst end", src_sent, 8);
      check(cnt_rdata == 92, "R7 OUT remaining count", cnt_rdata, 92);
      check(irq_stat == 2'b10, "R7 stop flag only", irq_stat, 2);
      check(exp_q.size() == 0, "R7 OUT FIFO drained", exp_q.size(), 0);
      clr_irq(2'b10);

      // R7 R5 graceful stop IN with endpoint held: FIFO fills to 8 then flushes
      new_test(7, 1, 16'd5);
      load(32'd30);
      do_cmd(8'h04);
      wait_sent(7);
      do_cmd(8'h13);
      src_lim = 200;
      repeat (20) @(negedge clk);
      check(src_sent == 8, "R5 intake stalls at 8 bytes", src_sent, 8);
      check(busy == 1, "R7 still draining", busy, 1);
      snk_mode = 0;
      wait_idle();
      check(src_sent == 10, "R7 IN stops at burst end", src_sent, 10);
      check(exp_q.size() == 0, "R7 IN FIFO flushed to endpoint", exp_q.size(), 0);
      check(cnt_rdata == 20, "R7 IN remaining count", cnt_rdata, 20);
      check(irq_stat == 2'b10, "R7 stop flag IN", irq_stat, 2);
      // R11 writing 0 keeps flag
      clr_irq(2'b01);
      check(irq_stat == 2'b10, "R11 zero write keeps flag", irq_stat, 2);
      clr_irq(2'b10);

      // R8 stop while idle
      do_cmd(8'h13);
      check(irq_stat == 2'b10, "R8 idle stop sets flag", irq_stat, 2);
      clr_irq(2'b10);

      // R9 abort immediate IN
      new_test(5, 1, 16'd4);
      load(32'd50);
      do_cmd(8'h06);
      wait_sent(5);
      do_cmd(8'h12);
      check(busy == 0, "R9 abort ends transfer", busy, 0);
      check(cnt_rdata == 50, "R9 abort keeps counter", cnt_rdata, 50);
      check(irq_stat == 2'b00, "R9 abort sets no flag", irq_stat, 0);
      exp_q.delete();
      snk_mode = 0;
      repeat (3) @(negedge clk);
      check(ep_wr_valid == 0, "R9 FIFO discarded", ep_wr_valid, 0);

      // R9 abort ignored in burst mode, R2 write ignored while busy
      new_test(100, 1, 16'd2);
      load(32'd6);
      do_cmd(8'h04);
      wait_sent(6);
      do_cmd(8'h12);
      check(busy == 1, "R9 abort no effect in burst mode", busy, 1);
      load(32'd999);
      check(cnt_rdata == 6, "R2 write ignored while busy", cnt_rdata, 6);
      // R10 reserved while running
      do_cmd(8'h1A);
      check(busy == 1, "R10 reserved keeps running", busy, 1);
      snk_mode = 0;
      wait_idle();
      check(irq_stat == 2'b01, "R4 done after ignored abort", irq_stat, 1);

      // R10 reserved codes while idle
      load(32'd77);
      do_cmd(8'h14); do_cmd(8'h20); do_cmd(8'h29); do_cmd(8'hFF);
      check(busy == 0, "R10 reserved no start", busy, 0);
      check(cnt_rdata == 77, "R10 reserved keeps counter", cnt_rdata, 77);
      check(irq_stat == 2'b01, "R10 reserved keeps flags", irq_stat, 1);
      clr_irq(2'b01);

      // R4 zero-count start
      new_test(0, 0, 16'd4);
      load(32'd0);
      do_cmd(8'h06);
      wait_idle();
      check(irq_stat == 2'b01, "R4 zero count done", irq_stat, 1);

      // R1 soft reset mid transfer
      new_test(100, 1, 16'd4);
      load(32'd40);
      do_cmd(8'h04);
      wait_sent(3);
      do_cmd(8'h11);
      check(busy == 0, "R1 soft reset stops", busy, 0);
      check(cnt_rdata == 0, "R1 soft reset counter", cnt_rdata, 0);
      check(irq_stat == 2'b00, "R1 soft reset flags", irq_stat, 0);
      exp_q.delete();
      snk_mode = 0;
      repeat (3) @(negedge clk);
      check(ep_wr_valid == 0, "R1 soft reset empties FIFO", ep_wr_valid, 0);

      finish_run();
   end

endmodule